// File: doc/BRIEF.md
# Graphics Aperture Window Decoder

This block sits in the address decode path of a host bridge. It decides whether a host memory access falls inside a programmable graphics aperture. An access that lands in the aperture goes to main memory through an address-translation lookup. For that lookup the block supplies the address offset relative to the aperture. The block also checks a second, independent graphics memory range. That range covers memory claimed by devices on the graphics port, including a 66 MHz PCI agent or the PCI-only functions of a multi-function device. Accesses in that range are sent to the graphics port without translation.

Software programs four registers through a simple write port and a combinational read port: the aperture base, an aperture control register holding the size code and an enable, and the graphics range base and limit. The size code sets how many of base bits 27:22 take part in the compare. The bits it removes from the compare are read-only and read as zero. When a size change makes a base bit writable again, that bit holds no defined value. The block flags this and blocks aperture hits until software writes the base. The two ranges may sit next to each other but must not overlap. If they are ever programmed to overlap, a sticky error flag is set.

Host requests are sampled on the clock edge. The hit flags, the route code and the offset appear at the outputs from the next edge onward.

Top module: `apwin_decoder`

## Requirements
- R1: After reset:
  - all decode outputs are 0;
  - the base reads 0x00000000 and the control register reads 0x00000006;
  - the graphics range base reads 0xFFF00000 and its limit reads 0x00000000;
  - the unknown flag and the overlap flag are 0.
- R2: The register select values are: 0 aperture base, 1 aperture control, 2 graphics range base, 3 graphics range limit. In the control register, bits 2:0 hold the size code and bit 7 is the aperture enable. Size code c gives a window of 4 MB << c, for c from 0 to 6. A written code of 7 is stored and read back as 6.
- R3: Base bits 31:28 are always writable, and base bits 21:0 always read as zero. Base bit 22+i (i = 0..5) is read-only and reads zero when i < size code. Growing the size clears any base bit that becomes read-only.
- R4: A control write that makes a base bit writable sets `base_unknown`. Until the base register is written again, no aperture hit is reported.
- R5: A sampled request hits the aperture when the aperture is enabled, no base bit is unknown, and `addr[31:22]` equals the base on every compared bit. `ap_hit` shows this from the following edge. With the enable clear there is never an aperture hit.
- R6: On an aperture hit, `ap_offset` is the request address with every compared bit cleared, giving a value from 0 to window size − 1. With no hit it is 0.
- R7: `route` is 0 when nothing hits, 1 for an aperture hit (translated main-memory access), and 2 for a graphics range hit.
- R8: The graphics range compares `addr[31:20]` against the base and limit fields (bits 31:20 of those registers), inclusive at both ends. The range is enabled only while base ≤ limit. An aperture hit takes priority, so `gm_hit` is never raised together with `ap_hit`.
- R9: `overlap_err` is set once an enabled aperture with a fully known base and an enabled graphics range share any address. Adjacent ranges do not set it. Once set, it stays set until reset.
- R10: A cycle without `req_valid` produces no hit of either kind on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register selected for writing |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 2 | Register selected for reading |
| cfg_rd_data | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Host request present |
| req_addr | input | 32 | Host memory address |
| ap_hit | output | 1 | Request hit the aperture |
| gm_hit | output | 1 | Request hit the graphics memory range |
| route | output | 2 | Routing target code |
| ap_offset | output | 32 | Aperture-relative offset for translation |
| base_unknown | output | 1 | Some compared base bit holds no defined value |
| overlap_err | output | 1 | Sticky range overlap error |

## Verification
The properties assume that requests and register writes are stable around each rising edge. They also assume that the read select is held while its data is observed, because the read-only-zero property inspects the read port whenever the base is selected. The bench changes every input half a period away from the active edge. Whenever it reprograms the aperture size, it writes the control register before the base, so the unknown-bit property only sees states that software can actually produce. The overlap property is exercised by deliberately programming an overlapping graphics limit after an adjacent, legal one.

// File: rtl/apwin_pkg.sv
package apwin_pkg;

  localparam int unsigned DFLT_ADDR_W  = 32;
  localparam int unsigned DFLT_AP_LSB  = 22;
  localparam int unsigned DFLT_SZ_BITS = 6;
  localparam int unsigned DFLT_GM_LSB  = 20;
  localparam int unsigned CTRL_EN_BIT  = 7;

  typedef enum logic [1:0] {
    ROUTE_NONE       = 2'd0,
    ROUTE_XLATE_DRAM = 2'd1,
    ROUTE_GFX_PORT   = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    SEL_AP_BASE  = 2'd0,
    SEL_AP_CTRL  = 2'd1,
    SEL_GM_BASE  = 2'd2,
    SEL_GM_LIMIT = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/apwin_cfg_regs.sv
module apwin_cfg_regs
  import apwin_pkg::*;
#(
  parameter int unsigned ADDR_W  = DFLT_ADDR_W,
  parameter int unsigned AP_LSB  = DFLT_AP_LSB,
  parameter int unsigned SZ_BITS = DFLT_SZ_BITS,
  parameter int unsigned GM_LSB  = DFLT_GM_LSB,
  localparam int unsigned CODE_W   = $clog2(SZ_BITS + 1),
  localparam int unsigned AP_TAG_W = ADDR_W - AP_LSB,
  localparam int unsigned GM_TAG_W = ADDR_W - GM_LSB,
  localparam int unsigned FIX_W    = AP_TAG_W - SZ_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [ADDR_W-1:0]   wr_data,
  input  logic [1:0]          rd_sel,
  output logic [ADDR_W-1:0]   rd_data,
  output logic [AP_TAG_W-1:0] ap_base_tag,
  output logic [AP_TAG_W-1:0] ap_tag_mask,
  output logic                ap_enable,
  output logic                base_unknown,
  output logic [CODE_W-1:0]   size_code,
  output logic [GM_TAG_W-1:0] gm_base_tag,
  output logic [GM_TAG_W-1:0] gm_limit_tag
);

  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(SZ_BITS);

  // state
  logic [CODE_W-1:0]   size_q,     size_d;
  logic                en_q,       en_d;
  logic [AP_TAG_W-1:0] base_q,     base_d;
  logic [SZ_BITS-1:0]  known_q,    known_d;
  logic [GM_TAG_W-1:0] gm_base_q,  gm_base_d;
  logic [GM_TAG_W-1:0] gm_limit_q, gm_limit_d;

  // decode helpers
  logic [CODE_W-1:0]   wr_code_raw;
  logic [CODE_W-1:0]   wr_code;
  logic [SZ_BITS-1:0]  field_mask_cur;
  logic [SZ_BITS-1:0]  field_mask_new;
  logic [SZ_BITS-1:0]  opened_bits;
  logic [AP_TAG_W-1:0] tag_mask_cur;

  always_comb begin
    wr_code_raw    = wr_data[CODE_W-1:0];
    wr_code        = (wr_code_raw > CODE_MAX) ? CODE_MAX : wr_code_raw;
    field_mask_cur = {SZ_BITS{1'b1}} << size_q;
    field_mask_new = {SZ_BITS{1'b1}} << wr_code;
    opened_bits    = field_mask_new & ~field_mask_cur;
    tag_mask_cur   = {{FIX_W{1'b1}}, field_mask_cur};
  end

  // next-state
  always_comb begin
    size_d     = size_q;
    en_d       = en_q;
    base_d     = base_q;
    known_d    = known_q;
    gm_base_d  = gm_base_q;
    gm_limit_d = gm_limit_q;
    case (reg_sel_e'(wr_sel))
      SEL_AP_BASE: begin
        base_d  = wr_data[ADDR_W-1:AP_LSB] & tag_mask_cur;
        known_d = {SZ_BITS{1'b1}};
      end
      SEL_AP_CTRL: begin
        size_d  = wr_code;
        en_d    = wr_data[CTRL_EN_BIT];
        // newly writable bits lose their value; newly read-only bits become a known zero
        known_d = (known_q & ~opened_bits) | ~field_mask_new;
        base_d[SZ_BITS-1:0] = base_q[SZ_BITS-1:0] & field_mask_new & ~opened_bits;
      end
      SEL_GM_BASE:  gm_base_d  = wr_data[ADDR_W-1:GM_LSB];
      SEL_GM_LIMIT: gm_limit_d = wr_data[ADDR_W-1:GM_LSB];
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q     <= CODE_MAX;
      en_q       <= 1'b0;
      base_q     <= '0;
      known_q    <= {SZ_BITS{1'b1}};
      gm_base_q  <= {GM_TAG_W{1'b1}};
      gm_limit_q <= '0;
    end else if (wr_en) begin
      size_q     <= size_d;
      en_q       <= en_d;
      base_q     <= base_d;
      known_q    <= known_d;
      gm_base_q  <= gm_base_d;
      gm_limit_q <= gm_limit_d;
    end
  end

  // read port
  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_sel))
      SEL_AP_BASE:  rd_data = {base_q, {AP_LSB{1'b0}}};
      SEL_AP_CTRL: begin
        rd_data[CODE_W-1:0]  = size_q;
        rd_data[CTRL_EN_BIT] = en_q;
      end
      SEL_GM_BASE:  rd_data = {gm_base_q, {GM_LSB{1'b0}}};
      SEL_GM_LIMIT: rd_data = {gm_limit_q, {GM_LSB{1'b0}}};
      default: ;
    endcase
  end

  assign ap_base_tag  = base_q;
  assign ap_tag_mask  = tag_mask_cur;
  assign ap_enable    = en_q;
  assign base_unknown = ~&known_q;
  assign size_code    = size_q;
  assign gm_base_tag  = gm_base_q;
  assign gm_limit_tag = gm_limit_q;

endmodule

// File: rtl/apwin_ap_match.sv
module apwin_ap_match
  import apwin_pkg::*;
#(
  parameter int unsigned ADDR_W = DFLT_ADDR_W,
  parameter int unsigned AP_LSB = DFLT_AP_LSB,
  localparam int unsigned AP_TAG_W = ADDR_W - AP_LSB
) (
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [AP_TAG_W-1:0] base_tag,
  input  logic [AP_TAG_W-1:0] tag_mask,
  input  logic                enable,
  input  logic                base_unknown,
  output logic                hit,
  output logic [ADDR_W-1:0]   offset
);

  logic [AP_TAG_W-1:0] tag_diff;
  logic [ADDR_W-1:0]   keep_mask;

  always_comb begin
    tag_diff  = (req_addr[ADDR_W-1:AP_LSB] ^ base_tag) & tag_mask;
    keep_mask = ~{tag_mask, {AP_LSB{1'b0}}};
    hit       = req_valid & enable & ~base_unknown & (tag_diff == '0);
    offset    = hit ? (req_addr & keep_mask) : '0;
  end

endmodule

// File: rtl/apwin_gm_match.sv
module apwin_gm_match
  import apwin_pkg::*;
#(
  parameter int unsigned ADDR_W = DFLT_ADDR_W,
  parameter int unsigned GM_LSB = DFLT_GM_LSB,
  localparam int unsigned GM_TAG_W = ADDR_W - GM_LSB
) (
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [GM_TAG_W-1:0] gm_base_tag,
  input  logic [GM_TAG_W-1:0] gm_limit_tag,
  output logic                range_en,
  output logic                in_range
);

  logic [GM_TAG_W-1:0] req_tag;

  always_comb begin
    req_tag  = req_addr[ADDR_W-1:GM_LSB];
    range_en = (gm_base_tag <= gm_limit_tag);
    in_range = req_valid & range_en &
               (req_tag >= gm_base_tag) & (req_tag <= gm_limit_tag);
  end

endmodule

// File: rtl/apwin_overlap_check.sv
module apwin_overlap_check
  import apwin_pkg::*;
#(
  parameter int unsigned ADDR_W = DFLT_ADDR_W,
  parameter int unsigned AP_LSB = DFLT_AP_LSB,
  parameter int unsigned GM_LSB = DFLT_GM_LSB,
  localparam int unsigned AP_TAG_W = ADDR_W - AP_LSB,
  localparam int unsigned GM_TAG_W = ADDR_W - GM_LSB,
  localparam int unsigned SHIFT    = AP_LSB - GM_LSB
) (
  input  logic [AP_TAG_W-1:0] ap_base_tag,
  input  logic [AP_TAG_W-1:0] ap_tag_mask,
  input  logic                ap_enable,
  input  logic                base_unknown,
  input  logic [GM_TAG_W-1:0] gm_base_tag,
  input  logic [GM_TAG_W-1:0] gm_limit_tag,
  input  logic                gm_enable,
  output logic                overlap
);

  // aperture bounds expressed at graphics-range granularity
  logic [GM_TAG_W-1:0] ap_lo;
  logic [GM_TAG_W-1:0] ap_hi;

  always_comb begin
    ap_lo   = {ap_base_tag, {SHIFT{1'b0}}};
    ap_hi   = {ap_base_tag | ~ap_tag_mask, {SHIFT{1'b1}}};
    overlap = ap_enable & ~base_unknown & gm_enable &
              (ap_lo <= gm_limit_tag) & (gm_base_tag <= ap_hi);
  end

endmodule

// File: rtl/apwin_decoder.sv
module apwin_decoder
  import apwin_pkg::*;
#(
  parameter int unsigned ADDR_W  = DFLT_ADDR_W,
  parameter int unsigned AP_LSB  = DFLT_AP_LSB,
  parameter int unsigned SZ_BITS = DFLT_SZ_BITS,
  parameter int unsigned GM_LSB  = DFLT_GM_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic [1:0]        cfg_rd_sel,
  output logic [ADDR_W-1:0] cfg_rd_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ap_hit,
  output logic              gm_hit,
  output logic [1:0]        route,
  output logic [ADDR_W-1:0] ap_offset,
  output logic              base_unknown,
  output logic              overlap_err
);

  localparam int unsigned CODE_W   = $clog2(SZ_BITS + 1);
  localparam int unsigned AP_TAG_W = ADDR_W - AP_LSB;
  localparam int unsigned GM_TAG_W = ADDR_W - GM_LSB;

  logic [AP_TAG_W-1:0] ap_base_tag_w;
  logic [AP_TAG_W-1:0] ap_tag_mask_w;
  logic                ap_enable_w;
  logic                base_unknown_w;
  logic [CODE_W-1:0]   size_code_w;
  logic [GM_TAG_W-1:0] gm_base_tag_w;
  logic [GM_TAG_W-1:0] gm_limit_tag_w;
  logic                ap_hit_c;
  logic [ADDR_W-1:0]   ap_offset_c;
  logic                gm_en_c;
  logic                gm_in_c;
  logic                overlap_c;

  apwin_cfg_regs #(
    .ADDR_W(ADDR_W), .AP_LSB(AP_LSB), .SZ_BITS(SZ_BITS), .GM_LSB(GM_LSB)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr_en),
    .wr_sel       (cfg_wr_sel),
    .wr_data      (cfg_wr_data),
    .rd_sel       (cfg_rd_sel),
    .rd_data      (cfg_rd_data),
    .ap_base_tag  (ap_base_tag_w),
    .ap_tag_mask  (ap_tag_mask_w),
    .ap_enable    (ap_enable_w),
    .base_unknown (base_unknown_w),
    .size_code    (size_code_w),
    .gm_base_tag  (gm_base_tag_w),
    .gm_limit_tag (gm_limit_tag_w)
  );

  apwin_ap_match #(.ADDR_W(ADDR_W), .AP_LSB(AP_LSB)) u_ap (
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .base_tag     (ap_base_tag_w),
    .tag_mask     (ap_tag_mask_w),
    .enable       (ap_enable_w),
    .base_unknown (base_unknown_w),
    .hit          (ap_hit_c),
    .offset       (ap_offset_c)
  );

  apwin_gm_match #(.ADDR_W(ADDR_W), .GM_LSB(GM_LSB)) u_gm (
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .gm_base_tag  (gm_base_tag_w),
    .gm_limit_tag (gm_limit_tag_w),
    .range_en     (gm_en_c),
    .in_range     (gm_in_c)
  );

  apwin_overlap_check #(.ADDR_W(ADDR_W), .AP_LSB(AP_LSB), .GM_LSB(GM_LSB)) u_ovl (
    .ap_base_tag  (ap_base_tag_w),
    .ap_tag_mask  (ap_tag_mask_w),
    .ap_enable    (ap_enable_w),
    .base_unknown (base_unknown_w),
    .gm_base_tag  (gm_base_tag_w),
    .gm_limit_tag (gm_limit_tag_w),
    .gm_enable    (gm_en_c),
    .overlap      (overlap_c)
  );

  // output stage
  logic              ap_hit_q,  ap_hit_d;
  logic              gm_hit_q,  gm_hit_d;
  route_e            route_q,   route_d;
  logic [ADDR_W-1:0] offset_q,  offset_d;
  logic              overlap_q, overlap_d;

  always_comb begin
    ap_hit_d  = ap_hit_c;
    gm_hit_d  = gm_in_c & ~ap_hit_c;
    offset_d  = ap_offset_c;
    overlap_d = overlap_q | overlap_c;
    if (ap_hit_c)     route_d = ROUTE_XLATE_DRAM;
    else if (gm_in_c) route_d = ROUTE_GFX_PORT;
    else              route_d = ROUTE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_hit_q  <= 1'b0;
      gm_hit_q  <= 1'b0;
      route_q   <= ROUTE_NONE;
      offset_q  <= '0;
      overlap_q <= 1'b0;
    end else begin
      ap_hit_q  <= ap_hit_d;
      gm_hit_q  <= gm_hit_d;
      route_q   <= route_d;
      offset_q  <= offset_d;
      overlap_q <= overlap_d;
    end
  end

  assign ap_hit       = ap_hit_q;
  assign gm_hit       = gm_hit_q;
  assign route        = route_q;
  assign ap_offset    = offset_q;
  assign base_unknown = base_unknown_w;
  assign overlap_err  = overlap_q;

endmodule

// File: rtl/apwin_decoder_checker.sv
module apwin_decoder_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned AP_LSB  = 22,
  parameter int unsigned SZ_BITS = 6,
  localparam int unsigned CODE_W = $clog2(SZ_BITS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        cfg_rd_sel,
  input logic [ADDR_W-1:0] cfg_rd_data,
  input logic              ap_hit,
  input logic              gm_hit,
  input logic [1:0]        route,
  input logic [ADDR_W-1:0] ap_offset,
  input logic              base_unknown,
  input logic              overlap_err,
  input logic [CODE_W-1:0] size_code
);

  logic [SZ_BITS-1:0] ro_field;
  assign ro_field = ~({SZ_BITS{1'b1}} << size_code);

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    size_code <= CODE_W'(SZ_BITS));

  p_ro_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_sel == 2'd0) |->
      (((cfg_rd_data[AP_LSB+SZ_BITS-1:AP_LSB] & ro_field) == '0) &&
       (cfg_rd_data[AP_LSB-1:0] == '0)));

  p_no_hit_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_unknown) |-> !ap_hit);

  p_offset_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_hit |-> (ap_offset == '0));

  p_offset_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ap_hit |-> (ap_offset[ADDR_W-1:AP_LSB+SZ_BITS] == '0));

  p_route_ap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ap_hit |-> (route == 2'd1));

  p_route_gm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gm_hit |-> (route == 2'd2));

  p_route_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ap_hit && !gm_hit) |-> (route == 2'd0));

  p_exclusive_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ap_hit && gm_hit));

  p_overlap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> overlap_err);

  p_idle_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!ap_hit && !gm_hit));

endmodule

bind apwin_decoder apwin_decoder_checker #(
  .ADDR_W(ADDR_W), .AP_LSB(AP_LSB), .SZ_BITS(SZ_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .cfg_rd_sel   (cfg_rd_sel),
  .cfg_rd_data  (cfg_rd_data),
  .ap_hit       (ap_hit),
  .gm_hit       (gm_hit),
  .route        (route),
  .ap_offset    (ap_offset),
  .base_unknown (base_unknown),
  .overlap_err  (overlap_err),
  .size_code    (size_code_w)
);

// File: tb/apwin_decoder_bench.sv
module apwin_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBL_BASE = 32'h4000_0000;

  typedef struct packed {
    logic [2:0]  code;
    logic [31:0] addr;
    logic        hit;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 32'h4000_0000, 1'b1},
    '{3'd0, 32'h403F_FFFF, 1'b1},
    '{3'd0, 32'h4040_0000, 1'b0},
    '{3'd1, 32'h407F_FFFF, 1'b1},
    '{3'd1, 32'h4080_0000, 1'b0},
    '{3'd2, 32'h40FF_FFFF, 1'b1},
    '{3'd2, 32'h4100_0000, 1'b0},
    '{3'd3, 32'h41FF_FFFF, 1'b1},
    '{3'd3, 32'h4200_0000, 1'b0},
    '{3'd4, 32'h43FF_FFFF, 1'b1},
    '{3'd4, 32'h4400_0000, 1'b0},
    '{3'd5, 32'h47FF_FFFF, 1'b1},
    '{3'd5, 32'h4800_0000, 1'b0},
    '{3'd6, 32'h4FFF_FFFF, 1'b1},
    '{3'd6, 32'h5000_0000, 1'b0},
    '{3'd6, 32'h3FFF_FFFF, 1'b0},
    '{3'd6, 32'h4000_0000, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [1:0]  cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic [1:0]  cfg_rd_sel;
  logic [31:0] cfg_rd_data;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        ap_hit;
  logic        gm_hit;
  logic [1:0]  route;
  logic [31:0] ap_offset;
  logic        base_unknown;
  logic        overlap_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  apwin_decoder u_apwin_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_addr(req_addr),
    .ap_hit(ap_hit), .gm_hit(gm_hit), .route(route), .ap_offset(ap_offset),
    .base_unknown(base_unknown), .overlap_err(overlap_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_sel  = sel;
    cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic cfg_read(input string req, input logic [1:0] sel, input logic [31:0] exp);
    cfg_rd_sel = sel;
    #1;
    check(req, "read", cfg_rd_data, exp);
    cfg_rd_sel = 2'd0;
  endtask

  task automatic access(input logic [31:0] addr, input logic valid);
    @(negedge clk);
    req_valid = valid;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_decode(input string req, input logic exp_ap, input logic exp_gm,
                              input logic [1:0] exp_route, input logic [31:0] exp_off);
    check(req, "ap_hit", {31'd0, ap_hit}, {31'd0, exp_ap});
    check(req, "gm_hit", {31'd0, gm_hit}, {31'd0, exp_gm});
    check(req, "route", {30'd0, route}, {30'd0, exp_route});
    check(req, "ap_offset", ap_offset, exp_off);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = 2'd0; cfg_wr_data = '0;
    cfg_rd_sel = 2'd0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_decode("R1", 1'b0, 1'b0, 2'd0, 32'h0);
    check("R1", "base_unknown", {31'd0, base_unknown}, 32'd0);
    check("R1", "overlap_err", {31'd0, overlap_err}, 32'd0);
    cfg_read("R1", 2'd0, 32'h0000_0000);
    cfg_read("R1", 2'd1, 32'h0000_0006);
    cfg_read("R1", 2'd2, 32'hFFF0_0000);
    cfg_read("R1", 2'd3, 32'h0000_0000);

    // R5 R6 R7 table: every size code, both window edges
    for (int i = 0; i < NVEC; i++) begin
      cfg_write(2'd1, 32'h80 | {29'd0, VECS[i].code});
      cfg_write(2'd0, TBL_BASE);
      access(VECS[i].addr, 1'b1);
      check_decode("R5", VECS[i].hit, 1'b0, VECS[i].hit ? 2'd1 : 2'd0,
                   VECS[i].hit ? (VECS[i].addr - TBL_BASE) : 32'h0);
    end

    // R2 code 7 clamps to 6
    cfg_write(2'd1, 32'h87);
    cfg_read("R2", 2'd1, 32'h0000_0086);

    // R3 R4 shrink to code 3: bits 27:25 reopen
    cfg_write(2'd1, 32'h83);
    check("R4", "base_unknown", {31'd0, base_unknown}, 32'd1);
    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_read("R3", 2'd0, 32'hFE00_0000);
    check("R4", "base_unknown", {31'd0, base_unknown}, 32'd0);

    // R4 shrink to code 1: bits 24:23 reopen, hits blocked
    cfg_write(2'd1, 32'h81);
    check("R4", "base_unknown", {31'd0, base_unknown}, 32'd1);
    cfg_read("R4", 2'd0, 32'hFE00_0000);
    access(32'hFE00_0004, 1'b1);
    check_decode("R4", 1'b0, 1'b0, 2'd0, 32'h0);
    cfg_write(2'd0, 32'hFE00_0000);
    check("R4", "base_unknown", {31'd0, base_unknown}, 32'd0);
    access(32'hFE00_0005, 1'b1);
    check_decode("R6", 1'b1, 1'b0, 2'd1, 32'h0000_0005);
    access(32'hFE7F_FFFF, 1'b1);
    check_decode("R6", 1'b1, 1'b0, 2'd1, 32'h007F_FFFF);
    access(32'hFE80_0000, 1'b1);
    check_decode("R5", 1'b0, 1'b0, 2'd0, 32'h0);

    // R3 grow to code 4: bits 25:22 forced to zero, no unknown
    cfg_write(2'd1, 32'h84);
    cfg_read("R3", 2'd0, 32'hFC00_0000);
    check("R3", "base_unknown", {31'd0, base_unknown}, 32'd0);
    access(32'hFFFF_FFFF, 1'b1);
    check_decode("R6", 1'b1, 1'b0, 2'd1, 32'h03FF_FFFF);

    // R8 graphics range
    cfg_write(2'd2, 32'h8000_0000);
    cfg_write(2'd3, 32'h80F1_2345);
    cfg_read("R8", 2'd3, 32'h80F0_0000);
    access(32'h8000_0000, 1'b1);
    check_decode("R8", 1'b0, 1'b1, 2'd2, 32'h0);
    access(32'h80FF_FFFF, 1'b1);
    check_decode("R8", 1'b0, 1'b1, 2'd2, 32'h0);
    access(32'h8100_0000, 1'b1);
    check_decode("R8", 1'b0, 1'b0, 2'd0, 32'h0);
    access(32'h7FFF_FFFF, 1'b1);
    check_decode("R8", 1'b0, 1'b0, 2'd0, 32'h0);

    // R9 adjacent ranges are legal
    cfg_write(2'd3, 32'hFBF0_0000);
    @(negedge clk);
    check("R9", "overlap_err adjacent", {31'd0, overlap_err}, 32'd0);
    access(32'hFBFF_FFFF, 1'b1);
    check_decode("R8", 1'b0, 1'b1, 2'd2, 32'h0);

    // R9 overlapping, then R8 priority
    cfg_write(2'd3, 32'hFC00_0000);
    @(negedge clk);
    check("R9", "overlap_err set", {31'd0, overlap_err}, 32'd1);
    access(32'hFC00_0010, 1'b1);
    check_decode("R8", 1'b1, 1'b0, 2'd1, 32'h0000_0010);
    cfg_write(2'd3, 32'h80F0_0000);
    repeat (2) @(negedge clk);
    check("R9", "overlap_err sticky", {31'd0, overlap_err}, 32'd1);

    // R10 no request, no hit
    access(32'hFC00_0020, 1'b0);
    check_decode("R10", 1'b0, 1'b0, 2'd0, 32'h0);

    // R5 aperture disabled
    cfg_write(2'd1, 32'h04);
    access(32'hFC00_0000, 1'b1);
    check_decode("R5", 1'b0, 1'b0, 2'd0, 32'h0);

    // R1 reset clears sticky flag and registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "overlap_err after reset", {31'd0, overlap_err}, 32'd0);
    cfg_read("R1", 2'd1, 32'h0000_0006);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule